// File: doc/BRIEF.md
# Floating-Point NaN Resolution Unit

This combinational unit sits beside an arithmetic datapath that performs add, subtract, multiply, divide, square root and fused multiply-add in binary64 or binary32. It looks only at the raw operand bit patterns, the operation code, a precision select and a default-NaN mode bit. From these it decides whether the result of the operation is a NaN. When it is, the unit supplies the exact NaN bits and says whether the invalid-operation exception is raised. The datapath uses `forced_o` to replace its own finite result with `result_o`.

Two sources of NaN are resolved here. The first is a NaN operand that is carried through to the result. A fixed priority picks that operand, and the unit either sets its quiet bit or replaces it with the default NaN. The second is an invalid operation on non-NaN operands, which produces the default NaN. Fused multiply-add adds one extra rule: a NaN that the operation generates takes the place of a quiet NaN coming from the addend.

Top module: `nan_resolve_unit`

## Requirements
- R1: With `dp_i`=0 (binary32) only bits [31:0] of each operand are examined, and `result_o[63:32]` is zero. With `dp_i`=1 all 64 bits form a binary64 value.
- R2: Among the operands that take part, a signalling NaN (exponent all ones, non-zero fraction, fraction MSB 0) is chosen over any quiet NaN (fraction MSB 1), whatever its position.
- R3: Among NaNs of the same kind, the operand with the lowest position wins. The positions are `opnd_a_i` (the addend for fused multiply-add), then `opnd_b_i`, then `opnd_c_i`.
- R4: With `dn_mode_i`=0 the chosen NaN is returned with its sign and payload kept and its quiet bit set: bit 51 for binary64, bit 22 for binary32.
- R5: With `dn_mode_i`=1 every forced result is the default NaN: 0x7FF8000000000000 for binary64 and 0x000000007FC00000 for binary32.
- R6: Add (op 0) of two infinities of opposite sign, and subtract (op 1) of two infinities of equal sign, give the default NaN with `invalid_o`=1.
- R7: Multiply (op 2) of an infinity and a zero, in either order, gives the default NaN with `invalid_o`=1. Divide (op 3) of infinity by infinity, or of zero by zero, does the same.
- R8: Square root (op 4) of any non-NaN operand with the sign bit set gives the default NaN with `invalid_o`=1, except minus zero, which is not forced.
- R9: Fused multiply-add (op 5, a + b*c) gives the default NaN with `invalid_o`=1 when the product is infinity times zero, or when an infinite addend has the opposite sign to an infinite product.
- R10: In fused multiply-add, a generated NaN replaces a quiet NaN addend with the default NaN and raises `invalid_o`. A signalling NaN in any operand still takes priority. A quiet NaN addend without a generated NaN propagates with `invalid_o`=0.
- R11: `invalid_o` is 1 exactly when a taking-part operand is a signalling NaN or a default NaN is generated by an invalid operation. A propagated quiet NaN alone gives 0.
- R12: Square root uses only `opnd_a_i`. The two-operand ops use `opnd_a_i` and `opnd_b_i`. Op codes 6 and 7 use no operand. Operands that are not used never affect the outputs.
- R13: When no NaN results, `forced_o`=0, `result_o`=0 and `invalid_o`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| op_i | input | 3 | Operation: 0 add, 1 sub, 2 mul, 3 div, 4 sqrt, 5 fused multiply-add |
| dp_i | input | 1 | 1 = binary64, 0 = binary32 |
| dn_mode_i | input | 1 | Default-NaN mode |
| opnd_a_i | input | 64 | Operand a (addend for fused multiply-add) |
| opnd_b_i | input | 64 | Operand b (first multiplicand) |
| opnd_c_i | input | 64 | Operand c (second multiplicand) |
| forced_o | output | 1 | Result is a NaN decided by this unit |
| result_o | output | 64 | Forced NaN bits, zero when not forced |
| invalid_o | output | 1 | Invalid-operation exception |

## Verification
NaN propagation and invalid-operation generation can be triggered by the same operand set. This happens most sharply in fused multiply-add, when a quiet NaN addend meets an infinity-times-zero product, or when a signalling NaN sits beside that product. The vector table drives these collisions, together with the plain single-cause cases for each operation. Each one is judged against the default NaN or the quieted operand that the priority rules call for, and against the expected invalid flag. Both precisions are covered, and junk in the upper half of binary32 operands and in unused operands shows that those bits change nothing.

// File: rtl/nanres_pkg.sv
package nanres_pkg;

  localparam int unsigned NR_WORD_W  = 64;
  localparam int unsigned NR_NUM_OPS = 3;

  localparam int unsigned NR_DP_EXP  = 11;
  localparam int unsigned NR_DP_FRAC = 52;
  localparam int unsigned NR_SP_EXP  = 8;
  localparam int unsigned NR_SP_FRAC = 23;

  typedef enum logic [2:0] {
    NR_ADD  = 3'd0,
    NR_SUB  = 3'd1,
    NR_MUL  = 3'd2,
    NR_DIV  = 3'd3,
    NR_SQRT = 3'd4,
    NR_FMA  = 3'd5
  } nr_op_e;

  typedef struct packed {
    logic sign;
    logic nan;
    logic snan;
    logic inf;
    logic zero;
  } nr_cls_t;

endpackage

// File: rtl/nanres_classify.sv
module nanres_classify
  import nanres_pkg::*;
#(
  parameter int unsigned EXP_W  = 11,
  parameter int unsigned FRAC_W = 52,
  localparam int unsigned FMT_W = EXP_W + FRAC_W + 1
) (
  input  logic [FMT_W-1:0] word_i,
  output nr_cls_t          cls_o
);

  logic [EXP_W-1:0]  exp_field;
  logic [FRAC_W-1:0] frac_field;
  logic              exp_ones;
  logic              exp_zero;
  logic              frac_zero;

  assign exp_field  = word_i[FMT_W-2 -: EXP_W];
  assign frac_field = word_i[FRAC_W-1:0];
  assign exp_ones   = &exp_field;
  assign exp_zero   = ~|exp_field;
  assign frac_zero  = ~|frac_field;

  always_comb begin
    cls_o.sign = word_i[FMT_W-1];
    cls_o.nan  = exp_ones & ~frac_zero;
    cls_o.snan = exp_ones & ~frac_zero & ~frac_field[FRAC_W-1];
    cls_o.inf  = exp_ones & frac_zero;
    cls_o.zero = exp_zero & frac_zero;
  end

endmodule

// File: rtl/nanres_operand.sv
module nanres_operand
  import nanres_pkg::*;
#(
  parameter int unsigned WORD_W = NR_WORD_W,
  parameter int unsigned DP_EXP = NR_DP_EXP,
  parameter int unsigned DP_FRA = NR_DP_FRAC,
  parameter int unsigned SP_EXP = NR_SP_EXP,
  parameter int unsigned SP_FRA = NR_SP_FRAC,
  localparam int unsigned DP_W  = DP_EXP + DP_FRA + 1,
  localparam int unsigned SP_W  = SP_EXP + SP_FRA + 1
) (
  input  logic [WORD_W-1:0] raw_i,
  input  logic              dp_i,
  output nr_cls_t           cls_o
);

  nr_cls_t cls_dp;
  nr_cls_t cls_sp;

  nanres_classify #(.EXP_W(DP_EXP), .FRAC_W(DP_FRA)) u_cls_dp (
    .word_i (raw_i[DP_W-1:0]),
    .cls_o  (cls_dp)
  );

  nanres_classify #(.EXP_W(SP_EXP), .FRAC_W(SP_FRA)) u_cls_sp (
    .word_i (raw_i[SP_W-1:0]),
    .cls_o  (cls_sp)
  );

  assign cls_o = dp_i ? cls_dp : cls_sp;

endmodule

// File: rtl/nanres_pick.sv
module nanres_pick
  import nanres_pkg::*;
#(
  parameter int unsigned N = NR_NUM_OPS
) (
  input  nr_cls_t        cls_i [N],
  input  logic [N-1:0]   live_i,
  output logic [N-1:0]   win_oh_o,
  output logic           any_nan_o,
  output logic           any_snan_o
);

  logic [N-1:0] snan_vec;
  logic [N-1:0] nan_vec;
  logic [N-1:0] snan_first;
  logic [N-1:0] nan_first;

  always_comb begin
    for (int i = 0; i < N; i++) begin
      snan_vec[i] = live_i[i] & cls_i[i].snan;
      nan_vec[i]  = live_i[i] & cls_i[i].nan;
    end
  end

  // lowest set bit of each vector
  assign snan_first = snan_vec & (~snan_vec + 1'b1);
  assign nan_first  = nan_vec  & (~nan_vec  + 1'b1);

  assign any_snan_o = |snan_vec;
  assign any_nan_o  = |nan_vec;
  assign win_oh_o   = any_snan_o ? snan_first : nan_first;

  always_comb begin
    p_pick_onehot_r3: assert ($onehot0(win_oh_o))
      else $error("pick: winner not one-hot");
    p_pick_on_nan_r2: assert ((win_oh_o & ~nan_vec) == '0)
      else $error("pick: winner is not a live NaN");
  end

endmodule

// File: rtl/nanres_invalid.sv
module nanres_invalid
  import nanres_pkg::*;
(
  input  logic [2:0] op_i,
  input  nr_cls_t    cls_a_i,
  input  nr_cls_t    cls_b_i,
  input  nr_cls_t    cls_c_i,
  output logic       gen_o
);

  logic prod_inf_zero;
  logic prod_inf;
  logic prod_sign;
  logic fma_gen;

  assign prod_inf_zero = (cls_b_i.inf & cls_c_i.zero) | (cls_c_i.inf & cls_b_i.zero);
  assign prod_inf      = cls_b_i.inf | cls_c_i.inf;
  assign prod_sign     = cls_b_i.sign ^ cls_c_i.sign;
  assign fma_gen       = prod_inf_zero |
                         (cls_a_i.inf & prod_inf & (cls_a_i.sign != prod_sign));

  always_comb begin
    unique case (op_i)
      NR_ADD:  gen_o = cls_a_i.inf & cls_b_i.inf & (cls_a_i.sign != cls_b_i.sign);
      NR_SUB:  gen_o = cls_a_i.inf & cls_b_i.inf & (cls_a_i.sign == cls_b_i.sign);
      NR_MUL:  gen_o = (cls_a_i.inf & cls_b_i.zero) | (cls_b_i.inf & cls_a_i.zero);
      NR_DIV:  gen_o = (cls_a_i.inf & cls_b_i.inf) | (cls_a_i.zero & cls_b_i.zero);
      NR_SQRT: gen_o = cls_a_i.sign & ~cls_a_i.zero & ~cls_a_i.nan;
      NR_FMA:  gen_o = fma_gen;
      default: gen_o = 1'b0;
    endcase
  end

  always_comb begin
    p_sqrt_negzero_r8: assert (!((op_i == NR_SQRT) && cls_a_i.zero && gen_o))
      else $error("invalid: zero square root flagged");
  end

endmodule

// File: rtl/nan_resolve_unit.sv
module nan_resolve_unit
  import nanres_pkg::*;
#(
  parameter int unsigned WORD_W = NR_WORD_W,
  localparam int unsigned N     = NR_NUM_OPS,
  localparam int unsigned SP_W  = NR_SP_EXP + NR_SP_FRAC + 1,
  localparam int unsigned DP_QB = NR_DP_FRAC - 1,
  localparam int unsigned SP_QB = NR_SP_FRAC - 1
) (
  input  logic [2:0]        op_i,
  input  logic              dp_i,
  input  logic              dn_mode_i,
  input  logic [WORD_W-1:0] opnd_a_i,
  input  logic [WORD_W-1:0] opnd_b_i,
  input  logic [WORD_W-1:0] opnd_c_i,
  output logic              forced_o,
  output logic [WORD_W-1:0] result_o,
  output logic              invalid_o
);

  localparam logic [WORD_W-1:0] DN_DP = WORD_W'(64'h7FF8_0000_0000_0000);
  localparam logic [WORD_W-1:0] DN_SP = WORD_W'(64'h0000_0000_7FC0_0000);

  logic [WORD_W-1:0] raw [N];
  nr_cls_t           cls [N];
  logic [N-1:0]      live;
  logic [N-1:0]      win_oh;
  logic              any_nan;
  logic              any_snan;
  logic              gen;
  logic              gen_only;
  logic              fma_override;
  logic              use_default;
  logic [WORD_W-1:0] chosen;
  logic [WORD_W-1:0] quieted;
  logic [WORD_W-1:0] default_nan;

  assign raw[0] = opnd_a_i;
  assign raw[1] = opnd_b_i;
  assign raw[2] = opnd_c_i;

  for (genvar g = 0; g < N; g++) begin : g_opnd
    nanres_operand u_opnd (
      .raw_i (raw[g]),
      .dp_i  (dp_i),
      .cls_o (cls[g])
    );
  end

  always_comb begin
    unique case (op_i)
      NR_ADD, NR_SUB, NR_MUL, NR_DIV: live = 3'b011;
      NR_SQRT:                        live = 3'b001;
      NR_FMA:                         live = 3'b111;
      default:                        live = 3'b000;
    endcase
  end

  nanres_pick #(.N(N)) u_pick (
    .cls_i      (cls),
    .live_i     (live),
    .win_oh_o   (win_oh),
    .any_nan_o  (any_nan),
    .any_snan_o (any_snan)
  );

  nanres_invalid u_inv (
    .op_i    (op_i),
    .cls_a_i (cls[0]),
    .cls_b_i (cls[1]),
    .cls_c_i (cls[2]),
    .gen_o   (gen)
  );

  always_comb begin
    chosen = '0;
    for (int i = 0; i < N; i++) begin
      if (win_oh[i]) chosen = chosen | raw[i];
    end
  end

  always_comb begin
    if (dp_i) begin
      quieted        = chosen;
      quieted[DP_QB] = 1'b1;
      default_nan    = DN_DP;
    end else begin
      quieted        = '0;
      quieted[SP_W-1:0] = chosen[SP_W-1:0];
      quieted[SP_QB] = 1'b1;
      default_nan    = DN_SP;
    end
  end

  assign gen_only     = gen & ~any_nan;
  assign fma_override = (op_i == NR_FMA) & gen & any_nan & ~any_snan & win_oh[0];
  assign use_default  = dn_mode_i | gen_only | fma_override;

  assign forced_o  = any_nan | gen_only;
  assign invalid_o = any_snan | gen_only | fma_override;
  assign result_o  = !forced_o   ? '0 :
                     use_default ? default_nan : quieted;

  always_comb begin
    p_forced_is_qnan_r4: assert (!forced_o ||
        (dp_i ? (&result_o[62:52] && result_o[DP_QB])
              : (&result_o[30:23] && result_o[SP_QB])))
      else $error("top: forced result not a quiet NaN");
    p_idle_clear_r13: assert (forced_o || (result_o == '0 && !invalid_o))
      else $error("top: outputs not clear when idle");
    p_invalid_forced_r11: assert (!invalid_o || forced_o)
      else $error("top: invalid without forced result");
    p_dn_default_r5: assert (!(forced_o && dn_mode_i) || result_o == default_nan)
      else $error("top: default-NaN mode not honoured");
    p_sp_upper_clear_r1: assert (dp_i || result_o[WORD_W-1:SP_W] == '0)
      else $error("top: binary32 upper half not clear");
  end

endmodule

// File: tb/tb_nan_resolve_unit.sv
module tb_nan_resolve_unit;

  typedef struct packed {
    logic [2:0]  op;
    logic        dp;
    logic        dn;
    logic [63:0] a;
    logic [63:0] b;
    logic [63:0] c;
    logic        f;
    logic [63:0] r;
    logic        inv;
  } vec_t;

  localparam logic [63:0] DQN  = 64'h7FF8_0000_0000_0000;
  localparam logic [63:0] PINF = 64'h7FF0_0000_0000_0000;
  localparam logic [63:0] NINF = 64'hFFF0_0000_0000_0000;
  localparam logic [63:0] PZ   = 64'h0;
  localparam logic [63:0] NZ   = 64'h8000_0000_0000_0000;
  localparam logic [63:0] ONE  = 64'h3FF0_0000_0000_0000;
  localparam logic [63:0] MONE = 64'hBFF0_0000_0000_0000;
  localparam logic [63:0] SN1  = 64'h7FF0_0000_0000_0001;
  localparam logic [63:0] SN1Q = 64'h7FF8_0000_0000_0001;
  localparam logic [63:0] SNN  = 64'hFFF4_0000_0000_0002;
  localparam logic [63:0] SNNQ = 64'hFFFC_0000_0000_0002;
  localparam logic [63:0] QAA  = 64'h7FF8_0000_0000_00AA;
  localparam logic [63:0] QBB  = 64'h7FF8_0000_0000_00BB;
  localparam logic [63:0] SQN  = 64'h0000_0000_7FC0_0000;

  localparam int NV = 35;
  localparam vec_t VEC [NV] = '{
    '{3'd0, 1'b1, 1'b0, ONE,  ONE,  PZ,   1'b0, PZ,   1'b0}, // R13
    '{3'd0, 1'b1, 1'b0, PINF, NINF, PZ,   1'b1, DQN,  1'b1}, // R6
    '{3'd0, 1'b1, 1'b0, PINF, PINF, PZ,   1'b0, PZ,   1'b0}, // R6
    '{3'd1, 1'b1, 1'b0, PINF, PINF, PZ,   1'b1, DQN,  1'b1}, // R6
    '{3'd1, 1'b1, 1'b0, PINF, NINF, PZ,   1'b0, PZ,   1'b0}, // R6
    '{3'd2, 1'b1, 1'b0, PINF, NZ,   PZ,   1'b1, DQN,  1'b1}, // R7
    '{3'd2, 1'b1, 1'b0, PZ,   NINF, PZ,   1'b1, DQN,  1'b1}, // R7
    '{3'd3, 1'b1, 1'b0, PINF, NINF, PZ,   1'b1, DQN,  1'b1}, // R7
    '{3'd3, 1'b1, 1'b0, PZ,   NZ,   PZ,   1'b1, DQN,  1'b1}, // R7
    '{3'd3, 1'b1, 1'b0, ONE,  PZ,   PZ,   1'b0, PZ,   1'b0}, // R7
    '{3'd4, 1'b1, 1'b0, MONE, PZ,   PZ,   1'b1, DQN,  1'b1}, // R8
    '{3'd4, 1'b1, 1'b0, NZ,   PZ,   PZ,   1'b0, PZ,   1'b0}, // R8
    '{3'd4, 1'b1, 1'b0, NINF, PZ,   PZ,   1'b1, DQN,  1'b1}, // R8
    '{3'd0, 1'b1, 1'b0, QAA,  SN1,  PZ,   1'b1, SN1Q, 1'b1}, // R2
    '{3'd0, 1'b1, 1'b0, QAA,  QBB,  PZ,   1'b1, QAA,  1'b0}, // R3
    '{3'd0, 1'b1, 1'b0, SN1,  SNN,  PZ,   1'b1, SN1Q, 1'b1}, // R3
    '{3'd2, 1'b1, 1'b0, ONE,  SNN,  PZ,   1'b1, SNNQ, 1'b1}, // R4
    '{3'd0, 1'b1, 1'b1, QAA,  ONE,  PZ,   1'b1, DQN,  1'b0}, // R5
    '{3'd5, 1'b1, 1'b0, QAA,  SN1,  ONE,  1'b1, SN1Q, 1'b1}, // R2
    '{3'd5, 1'b1, 1'b0, ONE,  QBB,  QAA,  1'b1, QBB,  1'b0}, // R3
    '{3'd5, 1'b1, 1'b0, PINF, PINF, MONE, 1'b1, DQN,  1'b1}, // R9
    '{3'd5, 1'b1, 1'b0, PINF, NINF, MONE, 1'b0, PZ,   1'b0}, // R9
    '{3'd5, 1'b1, 1'b0, ONE,  PINF, PZ,   1'b1, DQN,  1'b1}, // R9
    '{3'd5, 1'b1, 1'b0, QAA,  PZ,   PINF, 1'b1, DQN,  1'b1}, // R10
    '{3'd5, 1'b1, 1'b0, QAA,  ONE,  ONE,  1'b1, QAA,  1'b0}, // R10
    '{3'd5, 1'b1, 1'b0, SN1,  PINF, PZ,   1'b1, SN1Q, 1'b1}, // R10
    '{3'd4, 1'b1, 1'b0, ONE,  SN1,  SN1,  1'b0, PZ,   1'b0}, // R12
    '{3'd0, 1'b1, 1'b0, ONE,  ONE,  SN1,  1'b0, PZ,   1'b0}, // R12
    '{3'd0, 1'b0, 1'b0, 64'h7F80_0000, 64'hFF80_0000, PZ, 1'b1, SQN, 1'b1}, // R1
    '{3'd0, 1'b0, 1'b0, 64'hFFFF_FFFF_3F80_0000, 64'h7FF0_0000_3F80_0000, PZ, 1'b0, PZ, 1'b0}, // R1
    '{3'd2, 1'b0, 1'b0, 64'h7F80_0005, 64'h3F80_0000, PZ, 1'b1, 64'h7FC0_0005, 1'b1}, // R4
    '{3'd0, 1'b0, 1'b0, 64'hDEAD_BEEF_7FC0_0033, 64'h3F80_0000, PZ, 1'b1, 64'h7FC0_0033, 1'b0}, // R1
    '{3'd2, 1'b0, 1'b1, 64'h7F80_0005, 64'h3F80_0000, PZ, 1'b1, SQN, 1'b1}, // R5
    '{3'd0, 1'b1, 1'b0, 64'h0000_0000_7F80_0005, ONE, PZ, 1'b0, PZ, 1'b0}, // R1
    '{3'd6, 1'b1, 1'b0, SN1,  SN1,  SN1,  1'b0, PZ,   1'b0}  // R12
  };

  logic        clk = 1'b0;
  logic [2:0]  op;
  logic        dp, dn;
  logic [63:0] a, b, c;
  logic        forced;
  logic [63:0] result;
  logic        invalid;
  int          checks = 0;
  int          errors = 0;
  int          cycles = 0;
  logic        finished = 1'b0;

  always #2.5 clk = ~clk;

  nan_resolve_unit dut (
    .op_i      (op),
    .dp_i      (dp),
    .dn_mode_i (dn),
    .opnd_a_i  (a),
    .opnd_b_i  (b),
    .opnd_c_i  (c),
    .forced_o  (forced),
    .result_o  (result),
    .invalid_o (invalid)
  );

  task automatic apply(input logic [2:0] o, input logic p, input logic d,
                       input logic [63:0] va, input logic [63:0] vb, input logic [63:0] vc);
    @(negedge clk);
    op = o; dp = p; dn = d; a = va; b = vb; c = vc;
    @(posedge clk);
    #1;
  endtask

  task automatic check(input string tag, input logic ef, input logic [63:0] er, input logic ei);
    checks++;
    if (forced !== ef || result !== er || invalid !== ei) begin
      errors++;
      $display("FAIL %s: got forced=%0b result=%h invalid=%0b, expected forced=%0b result=%h invalid=%0b",
               tag, forced, result, invalid, ef, er, ei);
    end
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 20000 && !finished) begin
      errors++;
      $display("FAIL watchdog (all requirements): cycles %0d expected below 20000", cycles);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    op = 3'd0; dp = 1'b0; dn = 1'b0; a = '0; b = '0; c = '0;
    // R13: quiescent state with all-zero inputs
    apply(3'd0, 1'b0, 1'b0, PZ, PZ, PZ);
    check("R13 idle zero inputs", 1'b0, PZ, 1'b0);

    for (int i = 0; i < NV; i++) begin
      apply(VEC[i].op, VEC[i].dp, VEC[i].dn, VEC[i].a, VEC[i].b, VEC[i].c);
      check($sformatf("vector %0d (tag in table comment)", i), VEC[i].f, VEC[i].r, VEC[i].inv);
    end

    // R3: a lone signalling NaN is chosen from each fused multiply-add position
    for (int p = 0; p < 3; p++) begin
      apply(3'd5, 1'b1, 1'b0, (p == 0) ? SNN : ONE, (p == 1) ? SNN : ONE, (p == 2) ? SNN : ONE);
      check($sformatf("R3 fma snan in position %0d", p), 1'b1, SNNQ, 1'b1);
    end

    // R2: a quiet NaN ahead of a signalling NaN still loses
    for (int p = 0; p < 2; p++) begin
      apply(3'd5, 1'b1, 1'b0, (p == 0) ? QAA : ONE, QBB, (p == 0) ? SN1 : SN1);
      check($sformatf("R2 qnan before snan case %0d", p), 1'b1, SN1Q, 1'b1);
    end

    // R11: a propagated quiet NaN alone raises no invalid flag (binary32)
    apply(3'd3, 1'b0, 1'b0, 64'h3F80_0000, 64'hFFC0_0011, PZ);
    check("R11 binary32 quiet NaN divisor", 1'b1, 64'hFFC0_0011, 1'b0);

    finished = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule